// File: doc/BRIEF.md
# PHY Loopback Control Sequencer

This block drives the register accesses that switch a line-side PHY in or out of loopback. It sits above a management bus master. It asks that master for one register read or one register write at a time, and it waits for the master's completion pulse before it asks for the next access. A single start strobe, sampled together with an on/off level, starts a complete sequence. The block raises a one-cycle done pulse when the last write has completed.

Every sequence begins by reading the PHY identifier. The value read back chooses one of two register paths:

- For the two known identifiers, the block flips the loopback bit in the basic control register.
- For any other identifier, it changes two vendor-area registers. It touches them in one order when enabling loopback and in the opposite order when disabling it.

Each change is a read-modify-write. Only the one target bit differs from the value just read. The identifier last read stays visible on a port, so the path that was taken can be observed.

Top module: `phy_lpbk_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`, `done` and `mm_req` are low and `phy_id` is 0.
- R2: A `start` seen while idle makes `busy` rise on the next clock. In that same cycle `mm_req` pulses a read (`mm_wr`=0) of device 1, register 2. `busy` then stays high until the cycle of `done`.
- R3: Each request is a one-cycle `mm_req` pulse, raised only while `busy`. No new request is raised until `mm_done` has answered the previous one. The request that follows an answer is raised in the cycle right after the `mm_done` cycle.
- R4: If the identifier is 0x0043 or 0x0240, the accesses after the identifier read are exactly: read device 1 register 0, then write device 1 register 0.
- R5: For any other identifier with `lpbk_on`=1, the accesses are exactly: read then write device 1 register 0xC017 (bit 2), then read then write device 4 register 0xC000 (bit 15).
- R6: For any other identifier with `lpbk_on`=0, the order is reversed: device 4 register 0xC000 (bit 15) first, then device 1 register 0xC017 (bit 2).
- R7: Each write carries the value returned by the read just before it. The target bit is set when loopback is being enabled and cleared when it is being disabled, and every other bit is unchanged.
- R8: `done` is high for exactly one cycle, the cycle after the final write's `mm_done`. In that cycle `busy` is low and `mm_req` is low.
- R9: A `start` pulse while `busy` is ignored. The request stream of the running sequence is unchanged, and no further sequence follows it.
- R10: `phy_id` takes the identifier value in the cycle after the identifier read completes and holds it until the next identifier read.
- R11: An `mm_done` pulse while no request is outstanding is ignored. It causes no `done`, no `busy` and no change of `phy_id`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe, used only while idle |
| lpbk_on | input | 1 | 1 enables loopback, 0 disables; sampled with start |
| mm_req | output | 1 | One-cycle request to the management master |
| mm_wr | output | 1 | 1 = write request, 0 = read request |
| mm_dev | output | DEV_W | Target device address |
| mm_reg | output | REG_W | Target register address |
| mm_wdata | output | DAT_W | Write data |
| mm_done | input | 1 | Completion pulse from the master |
| mm_rdata | input | DAT_W | Read data, valid with mm_done |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| phy_id | output | DAT_W | Identifier from the last identifier read |

## Verification
A wrong step counter or path flag shows up at the very next request pulse. The device, register or direction would differ from the expected access list, and the scoreboard flags it within one master round trip. A corrupted held read value appears on the following write as a second flipped bit. A sticky or missing state transition shows up as an extra request after `done`, or as `done` never arriving. Both are caught within a few cycles of the final completion.

// File: rtl/phy_lpbk_seq.sv
module phy_lpbk_seq #(
  parameter int DEV_W     = 5,
  parameter int REG_W     = 16,
  parameter int DAT_W     = 16,
  parameter int ID_KNOWN0 = 16'h0043,
  parameter int ID_KNOWN1 = 16'h0240,
  parameter int ID_DEV    = 1,
  parameter int ID_REG    = 2,
  parameter int BAS_DEV   = 1,
  parameter int BAS_REG   = 0,
  parameter int BAS_BIT   = 0,
  parameter int XA_DEV    = 1,
  parameter int XA_REG    = 16'hC017,
  parameter int XA_BIT    = 2,
  parameter int XB_DEV    = 4,
  parameter int XB_REG    = 16'hC000,
  parameter int XB_BIT    = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             lpbk_on,
  output logic             mm_req,
  output logic             mm_wr,
  output logic [DEV_W-1:0] mm_dev,
  output logic [REG_W-1:0] mm_reg,
  output logic [DAT_W-1:0] mm_wdata,
  input  logic             mm_done,
  input  logic [DAT_W-1:0] mm_rdata,
  output logic             busy,
  output logic             done,
  output logic [DAT_W-1:0] phy_id
);
  localparam int BIT_W = (DAT_W > 1) ? $clog2(DAT_W) : 1;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} st_t;

  st_t             st;
  logic [2:0]      step;
  logic            on_q, basic_q, done_q;
  logic [DAT_W-1:0] id_q, rd_q;

  logic             use_b, second;
  logic [2:0]       last_step;
  logic [DEV_W-1:0] tgt_dev;
  logic [REG_W-1:0] tgt_reg;
  logic [BIT_W-1:0] tgt_bit;
  logic [DAT_W-1:0] mask;

  assign second    = step > 3'd2;
  assign use_b     = second ^ ~on_q;
  assign last_step = basic_q ? 3'd2 : 3'd4;

  always_comb begin
    if (step == 3'd0) begin
      tgt_dev = DEV_W'(ID_DEV);
      tgt_reg = REG_W'(ID_REG);
      tgt_bit = '0;
    end else if (basic_q) begin
      tgt_dev = DEV_W'(BAS_DEV);
      tgt_reg = REG_W'(BAS_REG);
      tgt_bit = BIT_W'(BAS_BIT);
    end else if (use_b) begin
      tgt_dev = DEV_W'(XB_DEV);
      tgt_reg = REG_W'(XB_REG);
      tgt_bit = BIT_W'(XB_BIT);
    end else begin
      tgt_dev = DEV_W'(XA_DEV);
      tgt_reg = REG_W'(XA_REG);
      tgt_bit = BIT_W'(XA_BIT);
    end
  end

  assign mask     = DAT_W'(1) << tgt_bit;
  assign mm_req   = (st == S_ISSUE);
  assign mm_wr    = (step != 3'd0) && !step[0];
  assign mm_dev   = tgt_dev;
  assign mm_reg   = tgt_reg;
  assign mm_wdata = on_q ? (rd_q | mask) : (rd_q & ~mask);
  assign busy     = (st != S_IDLE);
  assign done     = done_q;
  assign phy_id   = id_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      step    <= '0;
      on_q    <= 1'b0;
      basic_q <= 1'b0;
      done_q  <= 1'b0;
      id_q    <= '0;
      rd_q    <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          on_q <= lpbk_on;
          step <= '0;
          st   <= S_ISSUE;
        end
        S_ISSUE: st <= S_WAIT;
        S_WAIT: if (mm_done) begin
          if (step == 3'd0) begin
            id_q    <= mm_rdata;
            basic_q <= (mm_rdata == DAT_W'(ID_KNOWN0)) ||
                       (mm_rdata == DAT_W'(ID_KNOWN1));
          end else if (step[0]) begin
            rd_q <= mm_rdata;
          end
          if (step != 3'd0 && step == last_step) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            step <= step + 3'd1;
            st   <= S_ISSUE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/phy_lpbk_seq_chk.sv
module phy_lpbk_seq_chk #(
  parameter int DEV_W  = 5,
  parameter int REG_W  = 16,
  parameter int DAT_W  = 16,
  parameter int ID_DEV = 1,
  parameter int ID_REG = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             mm_req,
  input logic             mm_wr,
  input logic [DEV_W-1:0] mm_dev,
  input logic [REG_W-1:0] mm_reg,
  input logic [DAT_W-1:0] mm_wdata,
  input logic             mm_done,
  input logic [DAT_W-1:0] mm_rdata,
  input logic             busy,
  input logic             done,
  input logic [DAT_W-1:0] phy_id
);
  logic             outst, pend_rd;
  logic [DAT_W-1:0] last_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outst   <= 1'b0;
      pend_rd <= 1'b0;
      last_rd <= '0;
    end else begin
      if (mm_req) begin
        outst   <= 1'b1;
        pend_rd <= !mm_wr;
      end else if (mm_done) begin
        outst <= 1'b0;
      end
      if (mm_done && outst && pend_rd) last_rd <= mm_rdata;
    end
  end

  // R2
  first_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> mm_req && !mm_wr && mm_dev == DEV_W'(ID_DEV) && mm_reg == REG_W'(ID_REG));
  // R2
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  // R3
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mm_req |=> !mm_req);
  // R3
  one_outst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mm_req |-> !outst && busy);
  // R7
  wr_preserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_req && mm_wr) |-> $countones(mm_wdata ^ last_rd) <= 1);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !mm_req && $past(mm_done) && $past(outst));
  // R11
  stray_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_done && !outst) |=> !done && $stable(phy_id));
endmodule

bind phy_lpbk_seq phy_lpbk_seq_chk #(
  .DEV_W(DEV_W), .REG_W(REG_W), .DAT_W(DAT_W), .ID_DEV(ID_DEV), .ID_REG(ID_REG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mm_req(mm_req), .mm_wr(mm_wr),
  .mm_dev(mm_dev), .mm_reg(mm_reg), .mm_wdata(mm_wdata), .mm_done(mm_done),
  .mm_rdata(mm_rdata), .busy(busy), .done(done), .phy_id(phy_id)
);

// File: tb/phy_lpbk_seq_tb_top.sv
module phy_lpbk_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        lpbk_on = 1'b0;
  logic        mm_req, mm_wr, busy, done;
  logic [4:0]  mm_dev;
  logic [15:0] mm_reg, mm_wdata, phy_id;
  logic        mm_done = 1'b0;
  logic [15:0] mm_rdata = '0;

  always #2.5 clk = ~clk;

  phy_lpbk_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .lpbk_on(lpbk_on),
    .mm_req(mm_req), .mm_wr(mm_wr), .mm_dev(mm_dev), .mm_reg(mm_reg),
    .mm_wdata(mm_wdata), .mm_done(mm_done), .mm_rdata(mm_rdata),
    .busy(busy), .done(done), .phy_id(phy_id)
  );

  typedef struct {
    logic        wr;
    logic [4:0]  dev;
    logic [15:0] rg;
    logic [15:0] dat;
    string       tag;
  } item_t;

  item_t       expq[$];
  logic [15:0] regm [int];
  int n_chk = 0, n_fail = 0, n_req = 0, lat = 1;

  function automatic int key(input logic [4:0] d, input logic [15:0] r);
    return int'(d) * 65536 + int'(r);
  endfunction

  function automatic logic [15:0] mrd(input int k);
    return regm.exists(k) ? regm[k] : 16'h0000;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic wr, input logic [4:0] d, input logic [15:0] r,
                      input logic [15:0] v, input string tag);
    item_t it;
    it.wr = wr; it.dev = d; it.rg = r; it.dat = v; it.tag = tag;
    expq.push_back(it);
  endtask

  task automatic rmw(input logic [4:0] d, input logic [15:0] r, input int b,
                     input bit on, input string tag);
    logic [15:0] v, m;
    v = mrd(key(d, r));
    m = 16'h1 << b;
    push(1'b0, d, r, 16'h0, tag);
    push(1'b1, d, r, on ? (v | m) : (v & ~m), tag);
  endtask

  // Scoreboard driver: predicts the access list from the requirements
  task automatic plan_seq(input bit on, output logic [15:0] id);
    id = mrd(key(5'd1, 16'd2));
    push(1'b0, 5'd1, 16'd2, 16'h0, "R2");
    if (id == 16'h0043 || id == 16'h0240) begin
      rmw(5'd1, 16'h0000, 0, on, "R4");
    end else if (on) begin
      rmw(5'd1, 16'hC017, 2, on, "R5");
      rmw(5'd4, 16'hC000, 15, on, "R5");
    end else begin
      rmw(5'd4, 16'hC000, 15, on, "R6");
      rmw(5'd1, 16'hC017, 2, on, "R6");
    end
  endtask

  // Monitor and master model: pops expected items as requests appear
  initial begin
    forever begin
      @(negedge clk);
      while (mm_req) begin
        item_t it;
        n_req++;
        if (expq.size() == 0) begin
          chk(1'b0, "R9", "unexpected request", {11'd0, mm_dev, mm_reg}, 32'h0);
        end else begin
          it = expq.pop_front();
          chk(mm_wr == it.wr && mm_dev == it.dev && mm_reg == it.rg, it.tag,
              "access", {mm_wr, 10'd0, mm_dev, mm_reg}, {it.wr, 10'd0, it.dev, it.rg});
          if (it.wr) chk(mm_wdata == it.dat, "R7", "write data", mm_wdata, it.dat);
        end
        if (mm_wr) regm[key(mm_dev, mm_reg)] = mm_wdata;
        mm_rdata = mm_wr ? 16'hDEAD : mrd(key(mm_dev, mm_reg));
        repeat (lat) @(negedge clk);
        mm_done = 1'b1;
        @(negedge clk);
        mm_done = 1'b0;
        mm_rdata = 16'h0;
      end
    end
  end

  task automatic run_seq(input bit on, input bit poke_busy);
    logic [15:0] id;
    int w;
    plan_seq(on, id);
    @(negedge clk);
    start = 1'b1; lpbk_on = on;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2", "busy after start", busy, 1);
    w = 0;
    while (!done && w < 2000) begin
      @(negedge clk);
      w++;
      if (poke_busy && w == 3) begin
        start = 1'b1; lpbk_on = ~on;
      end else begin
        start = 1'b0;
      end
      if (!done) chk(busy == 1'b1 || w > 1990, "R2", "busy held", busy, 1);
    end
    start = 1'b0;
    chk(done == 1'b1, "R8", "done seen", done, 1);
    chk(expq.size() == 0, "R8", "items left at done", expq.size(), 0);
    chk(busy == 1'b0, "R8", "busy at done", busy, 0);
    chk(phy_id == id, "R10", "phy_id", phy_id, id);
    @(negedge clk);
    chk(done == 1'b0, "R8", "done width", done, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "WD", "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int r0;
    repeat (3) @(negedge clk);
    // R1
    chk(!busy && !done && !mm_req && phy_id == 16'h0, "R1", "reset outputs",
        {busy, done, mm_req, phy_id}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !mm_req && phy_id == 16'h0, "R1", "after reset",
        {busy, done, mm_req, phy_id}, 0);

    // R4 known id A, enable
    regm[key(5'd1, 16'd2)] = 16'h0043;
    regm[key(5'd1, 16'd0)] = 16'h1230;
    lat = 1;
    run_seq(1'b1, 1'b0);
    chk(mrd(key(5'd1, 16'd0)) == 16'h1231, "R4", "ctrl reg", mrd(key(5'd1, 16'd0)), 16'h1231);

    // R4 known id B, disable, slow master
    regm[key(5'd1, 16'd2)] = 16'h0240;
    regm[key(5'd1, 16'd0)] = 16'hFFFF;
    lat = 4;
    run_seq(1'b0, 1'b0);
    chk(mrd(key(5'd1, 16'd0)) == 16'hFFFE, "R4", "ctrl reg", mrd(key(5'd1, 16'd0)), 16'hFFFE);

    // R5 other id, enable
    regm[key(5'd1, 16'd2)] = 16'h1234;
    regm[key(5'd1, 16'hC017)] = 16'hA0A0;
    regm[key(5'd4, 16'hC000)] = 16'h0123;
    lat = 1;
    run_seq(1'b1, 1'b0);
    chk(mrd(key(5'd4, 16'hC000)) == 16'h8123, "R5", "dev4 reg", mrd(key(5'd4, 16'hC000)), 16'h8123);

    // R6 other id, disable, with R9 start poke while busy
    lat = 2;
    r0 = n_req;
    run_seq(1'b0, 1'b1);
    repeat (20) @(negedge clk);
    chk(n_req - r0 == 5, "R9", "request count", n_req - r0, 5);
    chk(!busy && expq.size() == 0, "R9", "idle after poke", busy, 0);
    chk(mrd(key(5'd1, 16'hC017)) == 16'hA0A0, "R6", "dev1 reg", mrd(key(5'd1, 16'hC017)), 16'hA0A0);

    // R5 identifier next to a known one; target bit already set
    regm[key(5'd1, 16'd2)] = 16'h0042;
    regm[key(5'd1, 16'hC017)] = 16'hFFFF;
    regm[key(5'd4, 16'hC000)] = 16'h0000;
    lat = 3;
    run_seq(1'b1, 1'b0);

    // R11 stray completion while idle
    @(negedge clk);
    mm_done = 1'b1;
    @(negedge clk);
    mm_done = 1'b0;
    chk(!done && !busy, "R11", "stray done", {done, busy}, 0);
    chk(phy_id == 16'h0042, "R11", "phy_id kept", phy_id, 16'h0042);
    repeat (5) @(negedge clk);
    chk(!busy && !mm_req, "R11", "still idle", {busy, mm_req}, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule